// File: doc/BRIEF.md
# Write-Completion Status Reporter

This block sits between a nonvolatile array and the host data bus and decides what a host read returns while an internal program cycle is running. A write sequencer outside the block raises a busy flag for the length of each self-timed program cycle and presents the last byte it loaded before that cycle began. While the flag is up, every host read is rewritten into a status word. The most significant bit returns the inverse of that byte's top bit. Bit 6 changes value from one read to the next, and the remaining bits pass straight through from the array. When the cycle ends, reads return the stored data unchanged.

A drive-low enable for a shared, wired-OR ready/busy line stays active for the whole program cycle. The bus driver is enabled only during a read strobe: chip-enable low, output-enable low and write-enable high. The control is a two-state machine. PH_READY is the idle phase and passes array data through. PH_PROGRAM is the busy phase and rewrites reads. Transition T_START goes from PH_READY to PH_PROGRAM when the busy flag is seen high, and captures the reference bit at that moment. Transition T_DONE goes from PH_PROGRAM back to PH_READY when the busy flag is seen low.

Top module: `write_status_reporter`

## Requirements
- R1: After reset the phase is PH_READY, so `rdy_pull_low_o` is 0.
- R2: `bus_oe_o` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. Any other combination leaves the bus released (0).
- R3: In PH_READY, a read returns `array_data_i` on all bits of `bus_o`.
- R4: In PH_PROGRAM, bit 7 of `bus_o` during a read is the inverse of bit 7 of `last_byte_i` as sampled on the clock edge of T_START.
- R5: In PH_PROGRAM, bit 6 of `bus_o` has opposite values in two successive reads. It holds one value for the whole duration of a single read strobe, however many clocks the strobe lasts.
- R6: `rdy_pull_low_o` rises on the first clock edge at which `busy_i` is 1 and falls on the first clock edge at which `busy_i` is 0. It is combinationally unaffected by `busy_i` between edges.
- R7: Changes of `last_byte_i` while in PH_PROGRAM have no effect on bit 7 of read data.
- R8: After T_DONE, reads return true array data again on every bit, including bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Program cycle in progress, from the write sequencer |
| last_byte_i | input | DATA_W | Last byte loaded before the program cycle |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| array_data_i | input | DATA_W | True data read from the array |
| bus_o | output | DATA_W | Data presented to the host bus |
| bus_oe_o | output | 1 | Bus driver enable (0 = high impedance) |
| rdy_pull_low_o | output | 1 | Drive-low enable for the shared ready/busy line |

## Verification
A phase register stuck in the wrong state appears at the ports one clock after the busy flag changes. It shows as a pull-low enable that does not follow the flag, and on the next read strobe as bit 7 or bit 6 differing from the array data. A wrong reference capture shows on the first busy read as a bit 7 equal to, rather than the inverse of, the last loaded byte. It also shows when the loaded byte is altered mid-cycle and bit 7 follows the new value. A toggle register that updates at the wrong moment shows either as a bit 6 that changes between samples of one long read, or as two successive reads returning the same bit 6.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    typedef enum logic [0:0] {
        PH_READY   = 1'b0,
        PH_PROGRAM = 1'b1
    } phase_e;
endpackage

// File: rtl/stat_cycle_fsm.sv
module stat_cycle_fsm
    import wsr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] last_byte_i,
    output logic              in_prog_o,
    output logic              poll_ref_o
);
    phase_e state_q, state_d;
    logic   poll_q;
    logic   take_start;

    // next-state: T_START and T_DONE
    always_comb begin
        state_d    = state_q;
        take_start = 1'b0;
        unique case (state_q)
            PH_READY: begin
                if (busy_i) begin
                    state_d    = PH_PROGRAM;
                    take_start = 1'b1;
                end
            end
            PH_PROGRAM: begin
                if (!busy_i) state_d = PH_READY;
            end
            default: state_d = PH_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_READY;
            poll_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_start) poll_q <= last_byte_i[POLL_BIT];
        end
    end

    // outputs
    always_comb begin
        in_prog_o  = (state_q == PH_PROGRAM);
        poll_ref_o = poll_q;
    end

    assert_ref_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog_o && $past(in_prog_o)) |-> $stable(poll_ref_o));
    assert_enter_prog_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |=> in_prog_o);
    assert_leave_prog_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_i) |=> !in_prog_o);
endmodule

// File: rtl/stat_toggle_gen.sv
module stat_toggle_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic in_prog_i,
    output logic toggle_o
);
    logic strobe_q;
    logic tog_q;
    logic strobe_end;

    always_comb strobe_end = strobe_q & ~strobe_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            tog_q    <= 1'b0;
        end else begin
            strobe_q <= strobe_i;
            if (strobe_end && in_prog_i) tog_q <= ~tog_q;
        end
    end

    always_comb toggle_o = tog_q;

    assert_steady_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && $past(strobe_i)) |-> $stable(toggle_o));
    assert_flip_per_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe_i) && !strobe_i && in_prog_i) |=> (toggle_o != $past(toggle_o)));
endmodule

// File: rtl/stat_bus_mux.sv
module stat_bus_mux #(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic              strobe_i,
    input  logic              in_prog_i,
    input  logic              poll_ref_i,
    input  logic              toggle_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              bus_oe_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == POLL_BIT) begin : g_poll
            always_comb bus_o[b] = in_prog_i ? ~poll_ref_i : array_data_i[b];
        end else if (b == TOGGLE_BIT) begin : g_tog
            always_comb bus_o[b] = in_prog_i ? toggle_i : array_data_i[b];
        end else begin : g_pass
            always_comb bus_o[b] = array_data_i[b];
        end
    end

    always_comb bus_oe_o = strobe_i;
endmodule

// File: rtl/write_status_reporter.sv
module write_status_reporter #(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] last_byte_i,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              bus_oe_o,
    output logic              rdy_pull_low_o
);
    localparam int MSB = DATA_W - 1;

    logic strobe;
    logic in_prog;
    logic poll_ref;
    logic toggle;

    always_comb strobe = ~ce_n & ~oe_n & we_n;

    stat_cycle_fsm #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_i),
        .last_byte_i(last_byte_i),
        .in_prog_o  (in_prog),
        .poll_ref_o (poll_ref)
    );

    stat_toggle_gen u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe),
        .in_prog_i(in_prog),
        .toggle_o (toggle)
    );

    stat_bus_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)) u_mux (
        .strobe_i    (strobe),
        .in_prog_i   (in_prog),
        .poll_ref_i  (poll_ref),
        .toggle_i    (toggle),
        .array_data_i(array_data_i),
        .bus_o       (bus_o),
        .bus_oe_o    (bus_oe_o)
    );

    always_comb rdy_pull_low_o = in_prog;

    assert_true_when_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_pull_low_o && bus_oe_o) |-> (bus_o == array_data_i));
    assert_poll_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_pull_low_o && bus_oe_o) |-> (bus_o[POLL_BIT] == ~poll_ref));
    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n) |-> !bus_oe_o);
    assert_msb_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (POLL_BIT <= MSB));
endmodule

// File: tb/write_status_reporter_tb.sv
module write_status_reporter_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         busy_i = 1'b0;
    logic [W-1:0] last_byte_i = '0;
    logic         ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [W-1:0] array_data_i = '0;
    logic [W-1:0] bus_o;
    logic         bus_oe_o;
    logic         rdy_pull_low_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    write_status_reporter #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .last_byte_i(last_byte_i),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .array_data_i(array_data_i),
        .bus_o(bus_o), .bus_oe_o(bus_oe_o), .rdy_pull_low_o(rdy_pull_low_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one read of HOLD clocks; returns bit 6 and checks bit 7 / data
    task automatic do_read(input logic [W-1:0] d, input int hold, input bit busy_exp,
                           input bit ref7, output bit b6);
        @(negedge clk);
        array_data_i = d; ce_n = 0; oe_n = 0; we_n = 1;
        #1;
        b6 = bus_o[6];
        for (int h = 0; h < hold; h++) begin
            @(posedge clk); #1;
            chk(bus_oe_o == 1'b1, "R2", bus_oe_o, 1);
            if (busy_exp) begin
                chk(bus_o[7] == ~ref7, "R4", bus_o[7], ~ref7);
                chk(bus_o[6] == b6, "R5", bus_o[6], b6);
            end else begin
                chk(bus_o == d, "R8", bus_o, d);
            end
        end
        @(negedge clk);
        ce_n = 1; oe_n = 1;
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit prev6, cur6;
        repeat (3) @(posedge clk);
        #1;
        chk(rdy_pull_low_o == 1'b0, "R1", rdy_pull_low_o, 0);
        chk(bus_oe_o == 1'b0, "R1", bus_oe_o, 0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        chk(rdy_pull_low_o == 1'b0, "R1", rdy_pull_low_o, 0);

        // R2: all enable combinations
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            ce_n = c[0]; oe_n = c[1]; we_n = c[2];
            #1;
            chk(bus_oe_o == (c == 4), "R2", bus_oe_o, (c == 4));
        end
        @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;

        // R3: sweep every data value while ready
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            array_data_i = v[7:0]; ce_n = 0; oe_n = 0; we_n = 1;
            #1;
            chk(bus_o == v[7:0], "R3", bus_o, v);
        end
        @(negedge clk); ce_n = 1; oe_n = 1;

        // program cycles with several loaded bytes
        for (int k = 0; k < 6; k++) begin
            logic [W-1:0] lb;
            lb = W'(k * 8'h35 + 8'h4c);
            if (k == 1) lb = 8'h00;
            if (k == 2) lb = 8'hff;
            @(negedge clk);
            last_byte_i = lb; busy_i = 1;
            #1;
            chk(rdy_pull_low_o == 1'b0, "R6", rdy_pull_low_o, 0);
            @(posedge clk); #1;
            chk(rdy_pull_low_o == 1'b1, "R6", rdy_pull_low_o, 1);
            @(negedge clk);
            last_byte_i = ~lb; // R7: must not matter
            for (int r = 0; r < 7; r++) begin
                do_read(W'(r * 8'h29 + k), 1 + (r % 3), 1'b1, lb[7], cur6);
                if (r > 0) chk(cur6 != prev6, "R5", cur6, ~prev6);
                prev6 = cur6;
            end
            @(negedge clk); ce_n = 0; oe_n = 0; #1;
            chk(bus_o[7] == ~lb[7], "R7", bus_o[7], ~lb[7]);
            ce_n = 1; oe_n = 1;
            @(negedge clk);
            busy_i = 0;
            #1;
            chk(rdy_pull_low_o == 1'b1, "R6", rdy_pull_low_o, 1);
            @(posedge clk); #1;
            chk(rdy_pull_low_o == 1'b0, "R6", rdy_pull_low_o, 0);
            // R8: true data back, bits 7 and 6 both ways
            for (int r = 0; r < 4; r++) begin
                logic [W-1:0] d;
                d = W'({r[1:0], 6'h15} ^ {lb[7], 7'h0});
                do_read(d, 2, 1'b0, 1'b0, cur6);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule